// File: doc/BRIEF.md
# Calendar Real-Time Clock Register Block

This block is a memory-mapped real-time clock. It holds a binary calendar time made of seconds, minutes, hours, day of month, month, two-digit year and century. While running is enabled, each pulse on a one-per-second tick input advances the time by one second. Minute, hour, day, month, year and century carries follow the calendar, and leap years are handled.

Software reaches the clock through a simple 32-bit register port with single-cycle access. Two packed counter words expose the time. A control word holds a run-enable bit and a write-unlock bit. Counter writes only take effect while the unlock bit is set, and each accepted counter write reloads the running time. While enable is clear, counter reads return the last stored snapshot instead of the live time. The remaining locations in the window read as zero and ignore writes.

Top module: `rtc_calendar_regs`

## Requirements
- R1: After reset every register reads zero, including the control word, so the clock is disabled and locked.
- R2: Word index `reg_addr[4:2]` selects the location: 0 is the time word, 1 is the date word, 4 is the control word. Every other index, including 2 and 5, reads zero and ignores writes, which disturb no other register.
- R3: The time word packs day of month at [28:24], hour at [20:16], minute at [13:8] and second at [5:0], all in binary. All other bits read zero, and written values in them are discarded.
- R4: The date word packs century at [20:16], year within the century (0-99) at [14:8] and month (1-12) at [3:0], all in binary. All other bits read zero.
- R5: Writes to the control word are always accepted. Bit 0 is enable and bit 1 is unlock. The other bits read zero.
- R6: While unlock is 0, writes to the time or date word are dropped and change neither the stored words nor the running time.
- R7: While unlock is 1, a counter write stores the word and, at the same clock edge, reloads the running time from both stored words. A tick in that same cycle is absorbed.
- R8: While enable is 1, a counter read returns the live time and updates the stored word. While enable is 0, a counter read returns the stored word unchanged.
- R9: Each tick advances the running time by one second while enable is 1. While enable is 0, ticks have no effect.
- R10: Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. Each wrap carries into the next field.
- R11: The day wraps to 1 after the last day of the month: 31 for months 1, 3, 5, 7, 8, 10 and 12, 30 for months 4, 6, 9 and 11, and 28 or 29 for month 2. A year is leap when century*100+year is divisible by 4, except when it is divisible by 100 but not by 400.
- R12: Month wraps from 12 to 1 and carries into the year. Year wraps from 99 to 0 and carries into the century, which wraps modulo 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read, qualified by reg_sel |
| reg_addr | input | ADDR_W | Byte address; bits [4:2] pick the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |

## Verification
The calendar is swept over the last days of every month of several years chosen to separate the leap rules: an ordinary year, a year divisible by 4, a century year divisible by 400, a century year that is not, a year-99 century carry and the top century. Each case is loaded at 23:59:59 and given a single tick, so one step shows whether the day, month, year and century carries happen at the right boundary. Lock, enable-snapshot and reserved-location cases are told apart by reading back the stored word with enable clear and the live word with enable set. A tick issued in the same cycle as a counter load shows whether the load absorbs it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int REG_W = 32;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int DAY_W  = 5;
    localparam int MON_W  = 4;
    localparam int YEAR_W = 7;
    localparam int CENT_W = 5;

    localparam int SEC_LSB  = 0;
    localparam int MIN_LSB  = 8;
    localparam int HOUR_LSB = 16;
    localparam int DAY_LSB  = 24;
    localparam int MON_LSB  = 0;
    localparam int YEAR_LSB = 8;
    localparam int CENT_LSB = 16;

    localparam int SEC_MAX  = 59;
    localparam int MIN_MAX  = 59;
    localparam int HOUR_MAX = 23;
    localparam int MON_MAX  = 12;
    localparam int YEAR_MAX = 99;

    localparam int WORD_TIME = 0;
    localparam int WORD_DATE = 1;
    localparam int WORD_CTRL = 4;

    localparam int EN_BIT     = 0;
    localparam int UNLOCK_BIT = 1;
    localparam int CTRL_W     = 2;

    typedef struct packed {
        logic [CENT_W-1:0] cent;
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  mon;
        logic [DAY_W-1:0]  day;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } rtc_time_t;

    typedef struct packed {
        logic [REG_W-1:0]  time_w;
        logic [REG_W-1:0]  date_w;
        logic [CTRL_W-1:0] ctrl;
    } rtc_regs_t;

    function automatic logic [REG_W-1:0] pack_time(input rtc_time_t t);
        logic [REG_W-1:0] w;
        w = '0;
        w[DAY_LSB  +: DAY_W]  = t.day;
        w[HOUR_LSB +: HOUR_W] = t.hour;
        w[MIN_LSB  +: MIN_W]  = t.min;
        w[SEC_LSB  +: SEC_W]  = t.sec;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] pack_date(input rtc_time_t t);
        logic [REG_W-1:0] w;
        w = '0;
        w[CENT_LSB +: CENT_W] = t.cent;
        w[YEAR_LSB +: YEAR_W] = t.year;
        w[MON_LSB  +: MON_W]  = t.mon;
        return w;
    endfunction

    function automatic rtc_time_t unpack_words(input logic [REG_W-1:0] tw,
                                               input logic [REG_W-1:0] dw);
        rtc_time_t t;
        t.day  = tw[DAY_LSB  +: DAY_W];
        t.hour = tw[HOUR_LSB +: HOUR_W];
        t.min  = tw[MIN_LSB  +: MIN_W];
        t.sec  = tw[SEC_LSB  +: SEC_W];
        t.cent = dw[CENT_LSB +: CENT_W];
        t.year = dw[YEAR_LSB +: YEAR_W];
        t.mon  = dw[MON_LSB  +: MON_W];
        return t;
    endfunction

    function automatic logic [REG_W-1:0] time_mask();
        rtc_time_t t;
        t = '1;
        return pack_time(t);
    endfunction

    function automatic logic [REG_W-1:0] date_mask();
        rtc_time_t t;
        t = '1;
        return pack_date(t);
    endfunction
endpackage

// File: rtl/rtc_month_days.sv
module rtc_month_days
    import rtc_pkg::*;
(
    input  logic [MON_W-1:0]  mon,
    input  logic [YEAR_W-1:0] year,
    input  logic [CENT_W-1:0] cent,
    output logic [DAY_W-1:0]  last_day
);
    logic leap;
    logic unused_cent;

    assign unused_cent = ^cent[CENT_W-1:2];

    // year < 100, so full%100 == year; full%400 == 0 then reduces to cent%4 == 0
    always_comb begin
        if (year == '0) leap = (cent[1:0] == 2'b00);
        else            leap = (year[1:0] == 2'b00);
    end

    always_comb begin
        case (mon)
            MON_W'(2):                       last_day = leap ? DAY_W'(29) : DAY_W'(28);
            MON_W'(4), MON_W'(6),
            MON_W'(9), MON_W'(11):           last_day = DAY_W'(30);
            default:                         last_day = DAY_W'(31);
        endcase
    end

    always_comb begin
        assert_len_range_R11: assert (last_day >= DAY_W'(28) && last_day <= DAY_W'(31));
    end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_en,
    input  rtc_time_t load_time,
    input  logic      adv_en,
    output rtc_time_t time_q
);
    rtc_time_t       time_d;
    logic [DAY_W-1:0] last_day;

    rtc_month_days u_days (
        .mon      (time_q.mon),
        .year     (time_q.year),
        .cent     (time_q.cent),
        .last_day (last_day)
    );

    always_comb begin
        time_d = time_q;
        if (load_en) begin
            time_d = load_time;
        end else if (adv_en) begin
            if (time_q.sec < SEC_W'(SEC_MAX)) begin
                time_d.sec = time_q.sec + SEC_W'(1);
            end else begin
                time_d.sec = '0;
                if (time_q.min < MIN_W'(MIN_MAX)) begin
                    time_d.min = time_q.min + MIN_W'(1);
                end else begin
                    time_d.min = '0;
                    if (time_q.hour < HOUR_W'(HOUR_MAX)) begin
                        time_d.hour = time_q.hour + HOUR_W'(1);
                    end else begin
                        time_d.hour = '0;
                        if (time_q.day < last_day) begin
                            time_d.day = time_q.day + DAY_W'(1);
                        end else begin
                            time_d.day = DAY_W'(1);
                            if (time_q.mon < MON_W'(MON_MAX)) begin
                                time_d.mon = time_q.mon + MON_W'(1);
                            end else begin
                                time_d.mon = MON_W'(1);
                                if (time_q.year < YEAR_W'(YEAR_MAX)) begin
                                    time_d.year = time_q.year + YEAR_W'(1);
                                end else begin
                                    time_d.year = '0;
                                    time_d.cent = time_q.cent + CENT_W'(1);
                                end
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) time_q <= '0;
        else        time_q <= time_d;
    end

    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> time_q == $past(load_time));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !adv_en) |=> $stable(time_q));

    assert_sec_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !load_en && time_q.sec < SEC_W'(SEC_MAX))
        |=> time_q.sec == $past(time_q.sec) + SEC_W'(1));

    assert_sec_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !load_en && time_q.sec == SEC_W'(SEC_MAX))
        |=> time_q.sec == '0);

    assert_mon_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !load_en && time_q.mon == MON_W'(MON_MAX) && time_q.day >= last_day
         && time_q.hour == HOUR_W'(HOUR_MAX) && time_q.min == MIN_W'(MIN_MAX)
         && time_q.sec == SEC_W'(SEC_MAX))
        |=> time_q.mon == MON_W'(1));
endmodule

// File: rtl/rtc_calendar_regs.sv
module rtc_calendar_regs
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [REG_W-1:0] TIME_MASK = time_mask();
    localparam logic [REG_W-1:0] DATE_MASK = date_mask();

    rtc_regs_t        regs_d, regs_q;
    rtc_time_t        live_q, load_time;
    logic             load_en, adv_en;
    logic [IDX_W-1:0] idx;
    logic [REG_W-1:0] live_time_w, live_date_w;
    logic             is_time, is_date, is_ctrl, is_wr, is_rd;
    logic             enabled, unlocked;
    logic             unused_addr;

    assign unused_addr = ^reg_addr[1:0];
    assign idx         = reg_addr[ADDR_W-1:2];
    assign is_time     = (idx == IDX_W'(WORD_TIME));
    assign is_date     = (idx == IDX_W'(WORD_DATE));
    assign is_ctrl     = (idx == IDX_W'(WORD_CTRL));
    assign is_wr       = reg_sel && reg_wr;
    assign is_rd       = reg_sel && !reg_wr;
    assign enabled     = regs_q.ctrl[EN_BIT];
    assign unlocked    = regs_q.ctrl[UNLOCK_BIT];
    assign live_time_w = pack_time(live_q);
    assign live_date_w = pack_date(live_q);
    assign adv_en      = sec_tick && enabled;

    always_comb begin
        regs_d  = regs_q;
        load_en = 1'b0;
        if (is_wr && is_ctrl) begin
            regs_d.ctrl = reg_wdata[CTRL_W-1:0];
        end
        if (is_wr && unlocked && is_time) begin
            regs_d.time_w = reg_wdata & TIME_MASK;
            load_en       = 1'b1;
        end
        if (is_wr && unlocked && is_date) begin
            regs_d.date_w = reg_wdata & DATE_MASK;
            load_en       = 1'b1;
        end
        if (is_rd && enabled && is_time) regs_d.time_w = live_time_w;
        if (is_rd && enabled && is_date) regs_d.date_w = live_date_w;
        load_time = unpack_words(regs_d.time_w, regs_d.date_w);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        if (is_time)      reg_rdata = enabled ? live_time_w : regs_q.time_w;
        else if (is_date) reg_rdata = enabled ? live_date_w : regs_q.date_w;
        else if (is_ctrl) reg_rdata = {{(REG_W-CTRL_W){1'b0}}, regs_q.ctrl};
        else              reg_rdata = '0;
    end

    rtc_time_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_time (load_time),
        .adv_en    (adv_en),
        .time_q    (live_q)
    );

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && !is_time && !is_date && !is_ctrl) |-> reg_rdata == '0);

    assert_ctrl_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && is_ctrl) |=> regs_q.ctrl == $past(reg_wdata[CTRL_W-1:0]));

    assert_locked_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && (is_time || is_date) && !unlocked)
        |=> (regs_q.time_w == $past(regs_q.time_w)) && (regs_q.date_w == $past(regs_q.date_w))
            && (live_q == $past(live_q)));

    assert_snapshot_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && !is_wr) |=> $stable(regs_q.time_w) && $stable(regs_q.date_w));

    assert_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.time_w & ~TIME_MASK) == '0 && (regs_q.date_w & ~DATE_MASK) == '0);
endmodule

// File: tb/rtc_calendar_regs_test.sv
module rtc_calendar_regs_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int m_sec, m_min, m_hour, m_day, m_mon, m_year, m_cent;

    rtc_calendar_regs #(.ADDR_W(5)) uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 0; reg_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_sel = 1; reg_wr = 0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_sel = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sec_tick = 1;
            @(negedge clk); sec_tick = 0;
        end
    endtask

    function automatic int days_in(input int m, input int fy);
        bit lp;
        lp = ((fy % 4 == 0) && (fy % 100 != 0)) || (fy % 400 == 0);
        if (m == 2) return lp ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] exp_time();
        return (32'(m_day) << 24) | (32'(m_hour) << 16) | (32'(m_min) << 8) | 32'(m_sec);
    endfunction

    function automatic logic [31:0] exp_date();
        return (32'(m_cent) << 16) | (32'(m_year) << 8) | 32'(m_mon);
    endfunction

    task automatic model_step();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hour++;
                if (m_hour == 24) begin
                    m_hour = 0; m_day++;
                    if (m_day > days_in(m_mon, m_cent * 100 + m_year)) begin
                        m_day = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1; m_year++;
                            if (m_year == 100) begin
                                m_year = 0; m_cent = (m_cent + 1) % 32;
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic set_model(input int c, input int y, input int mo, input int d,
                             input int h, input int mi, input int s);
        m_cent = c; m_year = y; m_mon = mo; m_day = d; m_hour = h; m_min = mi; m_sec = s;
    endtask

    // control must have unlock set
    task automatic load_model();
        wr(5'h04, exp_date());
        wr(5'h00, exp_time());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=%08h exp=%08h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, snap;
        int cents[6];
        int years[6];
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(5'h00, v); check("R1 time word", v, 0);
        rd(5'h04, v); check("R1 date word", v, 0);
        rd(5'h10, v); check("R1 control", v, 0);
        rd(5'h08, v); check("R1 alarm", v, 0);
        rd(5'h14, v); check("R1 alarm status", v, 0);

        // R6 locked writes dropped
        wr(5'h00, 32'h0A0B0C0D);
        wr(5'h04, 32'h00140305);
        rd(5'h00, v); check("R6 locked time stored", v, 0);
        rd(5'h04, v); check("R6 locked date stored", v, 0);
        wr(5'h10, 32'h1);
        rd(5'h00, v); check("R6 locked time live", v, 0);
        rd(5'h04, v); check("R6 locked date live", v, 0);

        // R5 control always writable, two bits
        wr(5'h10, 32'hFFFFFFFC);
        rd(5'h10, v); check("R5 ctrl upper ignored", v, 0);
        wr(5'h10, 32'hFFFFFFFF);
        rd(5'h10, v); check("R5 ctrl both bits", v, 3);
        wr(5'h10, 32'h2);
        rd(5'h10, v); check("R5 ctrl unlock only", v, 2);

        // R3 R4 packing and masks, disabled so stored words read back
        wr(5'h00, 32'hFFFFFFFF);
        rd(5'h00, v); check("R3 time mask", v, 32'h1F1F3F3F);
        wr(5'h04, 32'hFFFFFFFF);
        rd(5'h04, v); check("R4 date mask", v, 32'h001F7F0F);
        set_model(20, 24, 3, 15, 13, 45, 30);
        wr(5'h00, exp_time() | 32'hE0E0C0C0);
        rd(5'h00, v); check("R3 time fields", v, 32'h0F0D2D1E);
        wr(5'h04, exp_date() | 32'hFFE08070);
        rd(5'h04, v); check("R4 date fields", v, 32'h00141803);

        // R7 reload of live time from both words
        wr(5'h10, 32'h3);
        rd(5'h00, v); check("R7 live time after load", v, exp_time());
        rd(5'h04, v); check("R7 live date after load", v, exp_date());

        // R9 disabled ticks ignored, enabled ticks counted
        wr(5'h10, 32'h2);
        ticks(5);
        wr(5'h10, 32'h3);
        rd(5'h00, v); check("R9 no advance disabled", v, exp_time());
        ticks(5);
        for (int i = 0; i < 5; i++) model_step();
        rd(5'h00, v); check("R9 five ticks", v, exp_time());

        // R8 snapshot while disabled
        snap = exp_time();
        ticks(3);
        for (int i = 0; i < 3; i++) model_step();
        wr(5'h10, 32'h2);
        rd(5'h00, v); check("R8 disabled returns snapshot", v, snap);
        wr(5'h10, 32'h3);
        rd(5'h00, v); check("R8 enabled returns live", v, exp_time());
        wr(5'h10, 32'h2);
        rd(5'h00, v); check("R8 enabled read updated store", v, exp_time());
        wr(5'h10, 32'h3);

        // R7 tick absorbed in load cycle
        set_model(20, 25, 7, 4, 8, 0, 10);
        wr(5'h04, exp_date());
        @(negedge clk);
        reg_sel = 1; reg_wr = 1; reg_addr = 5'h00; reg_wdata = exp_time(); sec_tick = 1;
        @(negedge clk);
        reg_sel = 0; reg_wr = 0; sec_tick = 0;
        rd(5'h00, v); check("R7 tick absorbed", v, exp_time());

        // R10 field rollovers
        set_model(20, 25, 5, 10, 12, 34, 59);
        load_model(); ticks(1); model_step();
        rd(5'h00, v); check("R10 second carry", v, 32'h0A0C2300);
        set_model(20, 25, 5, 10, 23, 59, 59);
        load_model(); ticks(1); model_step();
        rd(5'h00, v); check("R10 hour carry to day", v, 32'h0B000000);

        // R2 reserved locations
        wr(5'h08, 32'hFFFFFFFF);
        wr(5'h14, 32'hFFFFFFFF);
        wr(5'h0C, 32'hFFFFFFFF);
        rd(5'h08, v); check("R2 alarm reads zero", v, 0);
        rd(5'h14, v); check("R2 alarm status zero", v, 0);
        rd(5'h0C, v); check("R2 gap zero", v, 0);
        rd(5'h18, v); check("R2 index 6 zero", v, 0);
        rd(5'h1C, v); check("R2 index 7 zero", v, 0);
        rd(5'h00, v); check("R2 time undisturbed", v, exp_time());
        rd(5'h04, v); check("R2 date undisturbed", v, exp_date());
        rd(5'h10, v); check("R2 ctrl undisturbed", v, 3);

        // R11 R12 sweep over month ends
        cents = '{20, 20, 20, 21, 19, 31};
        years = '{23, 24, 0, 0, 99, 99};
        for (int k = 0; k < 6; k++) begin
            for (int mo = 1; mo <= 12; mo++) begin
                for (int d = 27; d <= 31; d++) begin
                    if (d <= days_in(mo, cents[k] * 100 + years[k])) begin
                        set_model(cents[k], years[k], mo, d, 23, 59, 59);
                        load_model();
                        ticks(1);
                        model_step();
                        rd(5'h00, v); check("R11 day rollover", v, exp_time());
                        rd(5'h04, v); check("R12 date carry", v, exp_date());
                    end
                end
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule